// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block keeps a serial peripheral in one of three resting states (reset, run or pause) behind a small memory-mapped state register. Software writes a two-bit code into the low bits of that register. The controller then changes state and drops a read-only settled flag for a fixed number of core clocks. During that window any further state write is discarded. Bits above the flag are a software field that is kept as written. The controller drives an enable for the data path while it is in run. It also pulses a clear line to the FIFOs, the word counters and the operational flags each time it lands in reset.

Leaving pause for reset is guarded. Two clear-code writes must be accepted back to back. The first only arms the controller and leaves state and flag untouched, so the second can follow on the very next clock. A separate software-reset write strobe forces reset from anywhere, even while a change is still settling.

Top module: `run_state_ctrl`

## Requirements
- R1: After the asynchronous reset, the state is reset (code 0), the settled flag is high, the data-path enable and the FIFO clear are low, and the register reads 0x04.
- R2: Readback is {field[7:3], settled flag at bit 2, state code at bits 1:0}. The codes are reset = 0, run = 1, pause = 3, and state never reads 2. The data-path enable is high exactly while the state is run. A write with code 1 or 3 that is accepted moves to that state in the clock after the write.
- R3: Each state write that is accepted and changes or re-enters a state clears the settled flag from the next clock onward. The flag stays low for exactly 4 clocks and then returns high.
- R4: A state write arriving while the settled flag is low is ignored. State, field and flag timing are unchanged.
- R5: In pause, a single write of clear code 2 leaves the state in pause with the flag still high. A write of code 0 in pause is dropped and leaves the state, the field and the flag unchanged.
- R6: In pause, two consecutive accepted writes of code 2 move to reset on the second one. Any other write accepted between them cancels the first.
- R7: From run or reset, writing code 2 behaves exactly like writing code 0.
- R8: Each state write that is accepted, including the arming clear, stores write bits 7:3 into the field. Write bit 2 is ignored.
- R9: A software-reset write with bit 0 set forces reset and restarts the 4-clock settle window, whatever the state and the flag. If bit 0 is clear, that write has no effect.
- R10: The FIFO clear pulses high for exactly one clock, in the same clock that the state enters or re-enters reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| state_wr_i | input | 1 | write strobe for the state register |
| swrst_wr_i | input | 1 | write strobe for the software-reset register |
| wdata_i | input | REG_W | write data shared by both registers |
| state_rd_o | output | REG_W | state register readback |
| run_state_o | output | 2 | current state code |
| valid_o | output | 1 | settled flag |
| datapath_en_o | output | 1 | data path enable, high in run |
| fifo_clr_o | output | 1 | one-clock clear to FIFOs, counters and flags |

## Verification
The assertions assume that a write strobe lasts one clock for each intended write. They also assume that the two strobes are not raised together, although software reset wins if they are. The stimulus raises each strobe for a single clock from a task. It times writes against the settled window, sending them either after the flag has returned or deliberately inside it. Writes inside the window exercise the rule that busy writes are dropped, and a software reset is also sent in the middle of a settle window.

// File: rtl/run_state_pkg.sv
package run_state_pkg;
  typedef enum logic [1:0] {
    RS_RESET = 2'd0,
    RS_RUN   = 2'd1,
    RS_CLEAR = 2'd2,
    RS_PAUSE = 2'd3
  } rs_code_e;
endpackage

// File: rtl/rs_settle_timer.sv
module rs_settle_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic valid_o
);
  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int unsigned RUN_W = $clog2(SETTLE_CYC + 2);

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b1;
      cnt_q   <= '0;
    end else if (start_i) begin
      valid_q <= 1'b0;
      cnt_q   <= CNT_W'(SETTLE_CYC - 1);
    end else if (!valid_q) begin
      if (cnt_q == '0) valid_q <= 1'b1;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign valid_o = valid_q;

  // low-window length tracker for the checks below
  logic [RUN_W-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             low_run_q <= '0;
    else if (start_i || valid_q)             low_run_q <= '0;
    else if (low_run_q != RUN_W'(SETTLE_CYC + 1)) low_run_q <= low_run_q + 1'b1;
  end

  AST_SETTLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o); // R3
  AST_SETTLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (low_run_q < RUN_W'(SETTLE_CYC))); // R3
endmodule

// File: rtl/rs_state_fsm.sv
module rs_state_fsm
  import run_state_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       code_i,
  input  logic [REG_W-4:0] field_i,
  input  logic             swrst_i,
  input  logic             valid_i,
  output rs_code_e         state_o,
  output logic [REG_W-4:0] field_o,
  output logic             start_o,
  output logic             clr_o
);
  rs_code_e         state_q, code, nxt;
  logic [REG_W-4:0] field_q;
  logic             armed_q, clr_q;
  logic             acc, arm_only, drop;

  always_comb begin
    code     = rs_code_e'(code_i);
    acc      = wr_i && valid_i && !swrst_i;
    drop     = acc && (state_q == RS_PAUSE) && (code == RS_RESET);
    arm_only = acc && (state_q == RS_PAUSE) && (code == RS_CLEAR) && !armed_q;
    nxt      = (code == RS_CLEAR) ? RS_RESET : code;
    start_o  = swrst_i || (acc && !arm_only && !drop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_RESET;
      field_q <= '0;
      armed_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (swrst_i) begin
        state_q <= RS_RESET;
        armed_q <= 1'b0;
        clr_q   <= 1'b1;
      end else if (drop) begin
        armed_q <= 1'b0;
      end else if (acc) begin
        field_q <= field_i;
        if (arm_only) begin
          armed_q <= 1'b1;
        end else begin
          armed_q <= 1'b0;
          state_q <= nxt;
          clr_q   <= (nxt == RS_RESET);
        end
      end
    end
  end

  assign state_o = state_q;
  assign field_o = field_q;
  assign clr_o   = clr_q;

  AST_NO_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != RS_CLEAR); // R2
  AST_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !swrst_i) |=> ($stable(state_q) && $stable(field_q))); // R4
  AST_PAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && state_q == RS_PAUSE && !armed_q && (code == RS_CLEAR || code == RS_RESET))
      |=> state_q == RS_PAUSE); // R5
  AST_SWRST_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> state_q == RS_RESET); // R9
  AST_CLR_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> state_q == RS_RESET); // R10
endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import run_state_pkg::*;
#(
  parameter int unsigned REG_W      = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             state_wr_i,
  input  logic             swrst_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] state_rd_o,
  output logic [1:0]       run_state_o,
  output logic             valid_o,
  output logic             datapath_en_o,
  output logic             fifo_clr_o
);
  localparam int unsigned FIELD_W = REG_W - 3;

  rs_code_e           state;
  logic [FIELD_W-1:0] field;
  logic               settle_start, settled, swrst;
  logic               unused_flag_bit;

  assign swrst           = swrst_wr_i && wdata_i[0];
  assign unused_flag_bit = wdata_i[2];

  rs_state_fsm #(.REG_W(REG_W)) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (state_wr_i),
    .code_i  (wdata_i[1:0]),
    .field_i (wdata_i[REG_W-1:3]),
    .swrst_i (swrst),
    .valid_i (settled),
    .state_o (state),
    .field_o (field),
    .start_o (settle_start),
    .clr_o   (fifo_clr_o)
  );

  rs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (settle_start),
    .valid_o (settled)
  );

  assign run_state_o   = state;
  assign valid_o       = settled;
  assign datapath_en_o = (state == RS_RUN);
  assign state_rd_o    = {field, settled, state};

  AST_RUN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_wr_i && !swrst_wr_i && !valid_o && !datapath_en_o) |=> !datapath_en_o); // R4
endmodule

// File: tb/test_run_state_ctrl.sv
`timescale 1ns/1ps
module test_run_state_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       state_wr = 1'b0, swrst_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] state_rd_o;
  logic [1:0] run_state_o;
  logic       valid_o, datapath_en_o, fifo_clr_o;

  always #2 clk = ~clk;

  run_state_ctrl i_run_state_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .state_wr_i(state_wr), .swrst_wr_i(swrst_wr),
    .wdata_i(wdata), .state_rd_o(state_rd_o), .run_state_o(run_state_o),
    .valid_o(valid_o), .datapath_en_o(datapath_en_o), .fifo_clr_o(fifo_clr_o)
  );

  typedef struct {
    int unsigned when;
    logic [1:0]  st;
    logic        vld;
    logic        clr;
    logic [4:0]  fld;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int unsigned cyc = 0;
  int unsigned t = 0;
  int          n_tests = 0, n_fail = 0;
  logic [4:0]  fld_m = '0;
  logic [7:0]  exp_rd;
  logic        done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].when == cyc) begin
        exp_rd = {q[i].fld, q[i].vld, q[i].st};
        n_tests++;
        if (run_state_o !== q[i].st || valid_o !== q[i].vld || fifo_clr_o !== q[i].clr ||
            datapath_en_o !== (q[i].st == 2'd1) || state_rd_o !== exp_rd) begin
          n_fail++;
          $display("FAIL %s cyc %0d: st=%0d vld=%0b clr=%0b en=%0b rd=%02h, expected st=%0d vld=%0b clr=%0b en=%0b rd=%02h",
                   q[i].tag, cyc, run_state_o, valid_o, fifo_clr_o, datapath_en_o, state_rd_o,
                   q[i].st, q[i].vld, q[i].clr, (q[i].st == 2'd1), exp_rd);
        end
        q.delete(i);
      end
    end
  end

  task automatic chk(input int unsigned w, input logic [1:0] st, input logic vld,
                     input logic clr, input string tag);
    exp_t e;
    e.when = w; e.st = st; e.vld = vld; e.clr = clr; e.fld = fld_m; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr_state(input logic [7:0] d);
    @(posedge clk); #1;
    state_wr = 1'b1; swrst_wr = 1'b0; wdata = d; t = cyc + 1;
  endtask

  task automatic wr_swrst(input logic [7:0] d);
    @(posedge clk); #1;
    swrst_wr = 1'b1; state_wr = 1'b0; wdata = d; t = cyc + 1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      state_wr = 1'b0; swrst_wr = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  int unsigned ta;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    chk(cyc + 1, 2'd0, 1'b1, 1'b0, "R1");
    idle(2);

    // run, then a write inside the settle window
    fld_m = 5'h01;
    wr_state(8'h09); ta = t;
    chk(ta, 2'd1, 1'b0, 1'b0, "R3");
    chk(ta + 3, 2'd1, 1'b0, 1'b0, "R3");
    chk(ta + 4, 2'd1, 1'b1, 1'b0, "R2");
    wr_state(8'h1B);
    chk(ta + 1, 2'd1, 1'b0, 1'b0, "R4");
    chk(ta + 2, 2'd1, 1'b0, 1'b0, "R4");
    idle(5);

    // pause
    fld_m = 5'h00;
    wr_state(8'h03);
    chk(t, 2'd3, 1'b0, 1'b0, "R2");
    chk(t + 4, 2'd3, 1'b1, 1'b0, "R2");
    idle(5);

    // reset code dropped in pause
    wr_state(8'h00);
    chk(t, 2'd3, 1'b1, 1'b0, "R5");
    idle(2);

    // single clear holds pause, second one resets
    wr_state(8'h02);
    chk(t, 2'd3, 1'b1, 1'b0, "R5");
    wr_state(8'h02);
    chk(t, 2'd0, 1'b0, 1'b1, "R6");
    chk(t + 1, 2'd0, 1'b0, 1'b0, "R10");
    chk(t + 4, 2'd0, 1'b1, 1'b0, "R6");
    idle(5);

    // an intervening write cancels the arming clear
    wr_state(8'h01); idle(5);
    wr_state(8'h03); idle(5);
    wr_state(8'h02);
    wr_state(8'h03);
    chk(t, 2'd3, 1'b0, 1'b0, "R6");
    idle(5);
    wr_state(8'h02);
    chk(t, 2'd3, 1'b1, 1'b0, "R6");
    idle(1);
    wr_state(8'h02);
    chk(t, 2'd0, 1'b0, 1'b1, "R6");
    idle(5);

    // clear code from run and from reset
    wr_state(8'h01); idle(5);
    wr_state(8'h02);
    chk(t, 2'd0, 1'b0, 1'b1, "R7");
    idle(5);
    wr_state(8'h02);
    chk(t, 2'd0, 1'b0, 1'b1, "R7");
    idle(5);
    wr_state(8'h00);
    chk(t, 2'd0, 1'b0, 1'b1, "R10");
    chk(t + 1, 2'd0, 1'b0, 1'b0, "R10");
    idle(5);

    // field bits kept, bit 2 ignored
    fld_m = 5'h1F;
    wr_state(8'hFD);
    chk(t, 2'd1, 1'b0, 1'b0, "R8");
    chk(t + 4, 2'd1, 1'b1, 1'b0, "R8");
    idle(5);

    // software reset
    wr_swrst(8'h00);
    chk(t, 2'd1, 1'b1, 1'b0, "R9");
    idle(2);
    wr_swrst(8'h01);
    chk(t, 2'd0, 1'b0, 1'b1, "R9");
    chk(t + 4, 2'd0, 1'b1, 1'b0, "R9");
    idle(5);
    fld_m = 5'h00;
    wr_state(8'h01); ta = t;
    chk(ta, 2'd1, 1'b0, 1'b0, "R9");
    wr_swrst(8'h01);
    chk(t, 2'd0, 1'b0, 1'b1, "R9");
    chk(t + 3, 2'd0, 1'b0, 1'b0, "R9");
    chk(t + 4, 2'd0, 1'b1, 1'b0, "R9");
    idle(6);

    idle(3);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 pending expectations: %0d left, expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: run still busy at cycle %0d, expected finish", cyc);
      summary();
      $finish;
    end
  end
endmodule